// File: doc/BRIEF.md
# Coded Clock Output Divider with Glitch-Free Enable

This block takes a fast oscillator clock, divides it by a ratio picked with a 3-bit code, and fans the result out to six true/complement output pairs. Every ratio gives a 50% duty cycle. The divide-by-one setting passes the oscillator clock through a clock gate. All other ratios come from a single half-period counter that drives a toggle flop.

An output enable turns the pairs on and off. The enable is sampled on an oscillator rising edge and applied on a later falling edge. It is applied only while the selected clock is low. As a result, a high phase is never cut short, and a high phase never starts partway through. A new divide code takes effect only at the end of a low phase, so the period in progress always completes. An active-low asynchronous reset clears the counter and the enable. While reset is held, the pairs show true low and complement high.

Top module: `vco_out_divider`

## Requirements
- R1: The divide code selects the ratio as follows: 0 gives /2, 1 gives /4, 2 gives /8, 3 gives /16, 4 gives /1, 5 gives /2, 6 gives /4 and 7 gives /8. For any ratio N of 2 or more, the output is high for N/2 oscillator cycles and then low for N/2 cycles.
- R2: At code 4 (/1), the enabled output is high during each oscillator high phase and low during each oscillator low phase.
- R3: All six true outputs always carry the same value, and each complement output is always the inverse of its true output.
- R4: While the enable is settled low, every true output is 0 and every complement output is 1.
- R5: An enable change is sampled on an oscillator rising edge and applied on the following falling edge, provided the selected clock is low at that falling edge. At /1 this delays the effect by exactly one oscillator cycle.
- R6: For ratios of 2 or more, a disable that arrives during a high phase lets that phase finish at its full length. An enable that arrives during a divider high phase keeps the output low until the next full high phase begins.
- R7: A divide code change is applied only at the rising transition of the divided clock. The current high and low phases complete at the old ratio.
- R8: While rst_ni is low, all true outputs are 0 and all complement outputs are 1, immediately and without waiting for a clock. After release, the first rising edge loads the code, and the output starts with a full low phase at that ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low master reset |
| oe_i | input | 1 | Output enable, high to drive the clock onto the pairs |
| code_i | input | 3 | Divide ratio code |
| fout_o | output | 6 | True outputs of the six pairs |
| fout_n_o | output | 6 | Complement outputs of the six pairs |

## Verification
The bench changes the divide code partway through a /16 high phase. It then expects the full 8+8 cycle period, followed by /2 phases. A design that loaded the code at once would show a shortened high or low run.

The enable is dropped while the /16 output is high and raised while the divider is high. A gate that acted at the next edge would produce a clipped pulse in the first case and a partial pulse in the second.

The /1 enable tests count the exact cycle of effect, which catches a missing or doubled synchronizing stage. Reset is asserted during a high phase of the /1 clock. An output that waited for an edge to go low would fail that check.

// File: rtl/vco_div_pkg.sv
`timescale 1ns/1ps
package vco_div_pkg;
  localparam int unsigned CODE_W   = 3;
  localparam int unsigned HALF_MAX = 8;
  localparam int unsigned HALF_W   = $clog2(HALF_MAX + 1);
  localparam int unsigned CNT_W    = $clog2(HALF_MAX);

  // half-period length in oscillator cycles; 0 marks pass-through (/1)
  function automatic logic [HALF_W-1:0] code_half(input logic [CODE_W-1:0] code);
    logic [HALF_W-1:0] h;
    case (code)
      3'd0:    h = HALF_W'(1);
      3'd1:    h = HALF_W'(2);
      3'd2:    h = HALF_W'(4);
      3'd3:    h = HALF_W'(8);
      3'd4:    h = '0;
      3'd5:    h = HALF_W'(1);
      3'd6:    h = HALF_W'(2);
      default: h = HALF_W'(4);
    endcase
    return h;
  endfunction
endpackage

// File: rtl/vco_div_counter.sv
`timescale 1ns/1ps
module vco_div_counter
  import vco_div_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              div_o,
  output logic              bypass_o
);
  logic [HALF_W-1:0] half_q;
  logic [HALF_W-1:0] half_nxt;
  logic [CNT_W-1:0]  cnt_q;
  logic              start_q;
  logic              at_end;
  logic              boundary;

  assign half_nxt = code_half(code_i);
  assign bypass_o = (half_q == '0);
  assign at_end   = (HALF_W'(cnt_q) == half_q - HALF_W'(1));
  // period boundary: end of a low phase, every edge in /1, first edge after reset
  assign boundary = start_q | bypass_o | (!div_o && at_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q  <= '0;
      cnt_q   <= '0;
      div_o   <= 1'b0;
      start_q <= 1'b1;
    end else if (boundary) begin
      half_q  <= half_nxt;
      cnt_q   <= '0;
      div_o   <= !(start_q | bypass_o) && (half_nxt != '0);
      start_q <= 1'b0;
    end else if (at_end) begin
      cnt_q <= '0;
      div_o <= 1'b0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  a_r7_ratio_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary |=> $stable(half_q));
  a_r1_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_q != '0) |-> (HALF_W'(cnt_q) < half_q));
  a_r2_bypass_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_o |-> !div_o);
endmodule

// File: rtl/vco_div_gate.sv
`timescale 1ns/1ps
module vco_div_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oe_i,
  input  logic div_i,
  input  logic bypass_i,
  output logic gate_o,
  output logic sel1_o
);
  logic oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= oe_i;
  end

  // falling edge: clk is low here, so the /1 path and the gate switch cleanly
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel1_o <= 1'b0;
      gate_o <= 1'b0;
    end else begin
      sel1_o <= bypass_i;
      if (sel1_o || !div_i) gate_o <= oe_q;
    end
  end

  a_r6_gate_when_low: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!sel1_o && div_i) |=> $stable(gate_o));
  a_r5_oe_follow: assert property (@(negedge clk_i) disable iff (!rst_ni)
    sel1_o |=> (gate_o == $past(oe_q)));
endmodule

// File: rtl/vco_out_divider.sv
`timescale 1ns/1ps
module vco_out_divider
  import vco_div_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 oe_i,
  input  logic [CODE_W-1:0]    code_i,
  output logic [NUM_PAIRS-1:0] fout_o,
  output logic [NUM_PAIRS-1:0] fout_n_o
);
  logic div_q;
  logic bypass;
  logic gate_q;
  logic sel1_q;
  logic src;
  logic clk_out;

  vco_div_counter i_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .code_i   (code_i),
    .div_o    (div_q),
    .bypass_o (bypass)
  );

  vco_div_gate i_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .oe_i     (oe_i),
    .div_i    (div_q),
    .bypass_i (bypass),
    .gate_o   (gate_q),
    .sel1_o   (sel1_q)
  );

  assign src     = sel1_q ? clk_i : div_q;
  assign clk_out = src & gate_q;

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    assign fout_o[g]   = clk_out;
    assign fout_n_o[g] = ~clk_out;
  end

  a_r8_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (fout_o == '0));
endmodule

// File: tb/test_vco_out_divider.sv
`timescale 1ns/1ps
module test_vco_out_divider;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       oe = 1'b1;
  logic [2:0] code = 3'd0;
  logic [5:0] fout;
  logic [5:0] fout_n;

  int n_chk = 0;
  int n_err = 0;
  int pair_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vco_out_divider i_vco_out_divider (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .oe_i     (oe),
    .code_i   (code),
    .fout_o   (fout),
    .fout_n_o (fout_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_pairs();
    if (!((fout == 6'h00) || (fout == 6'h3f)) || (fout_n != ~fout)) pair_err++;
  endtask

  task automatic step_hi(output logic s);
    @(posedge clk); #5;
    chk_pairs();
    s = fout[0];
  endtask

  task automatic step_lo(output logic s);
    @(negedge clk); #5;
    chk_pairs();
    s = fout[0];
  endtask

  task automatic wait_rise();
    logic p, s;
    bit found;
    p = 1'b1;
    found = 1'b0;
    for (int i = 0; i < 80; i++) begin
      step_hi(s);
      if (!p && s) begin
        found = 1'b1;
        break;
      end
      p = s;
    end
    chk(found, "R1 rise seen", int'(found), 1);
  endtask

  // current sample is the first high cycle; ends on the next first high cycle
  task automatic run_len(output int h, output int l);
    logic s;
    h = 1;
    for (int i = 0; i < 40; i++) begin
      step_hi(s);
      if (!s) break;
      h++;
    end
    l = 1;
    for (int i = 0; i < 40; i++) begin
      step_hi(s);
      if (s) break;
      l++;
    end
  endtask

  function automatic int exp_div(input logic [2:0] c);
    case (c)
      3'd0: return 2;  3'd1: return 4;  3'd2: return 8;  3'd3: return 16;
      3'd4: return 1;  3'd5: return 2;  3'd6: return 4;  default: return 8;
    endcase
  endfunction

  task automatic t_reset_state();
    logic s;
    step_hi(s);
    chk(fout == 6'h00 && fout_n == 6'h3f, "R8 reset hi phase", int'(fout), 0);
    step_lo(s);
    chk(fout == 6'h00 && fout_n == 6'h3f, "R8 reset lo phase", int'(fout_n), 63);
    rst_ni = 1'b1;
  endtask

  task automatic t_ratio(input logic [2:0] c);
    int h, l, n;
    n = exp_div(c);
    code = c;
    wait_rise();
    run_len(h, l);
    run_len(h, l);
    run_len(h, l);
    chk(h == n / 2, $sformatf("R1 code %0d high run", c), h, n / 2);
    chk(l == n / 2, $sformatf("R1 code %0d low run", c), l, n / 2);
    chk(h == l, $sformatf("R1 code %0d duty", c), h, l);
  endtask

  task automatic t_bypass();
    logic s;
    int bad;
    code = 3'd4;
    for (int i = 0; i < 30; i++) step_hi(s);
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      step_hi(s); if (s !== 1'b1) bad++;
      step_lo(s); if (s !== 1'b0) bad++;
    end
    chk(bad == 0, "R2 pass-through follows clock", bad, 0);
  endtask

  task automatic t_oe_bypass();
    logic s;
    int bad;
    step_lo(s);
    oe = 1'b0;
    step_hi(s);
    chk(s == 1'b1, "R5 disable not before sampling edge", int'(s), 1);
    step_lo(s);
    step_hi(s);
    chk(s == 1'b0, "R5 disable after one cycle", int'(s), 0);
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      step_hi(s);
      if (fout != 6'h00 || fout_n != 6'h3f) bad++;
    end
    chk(bad == 0, "R4 disabled levels", bad, 0);
    step_lo(s);
    oe = 1'b1;
    step_hi(s);
    chk(s == 1'b0, "R5 enable not before sampling edge", int'(s), 0);
    step_lo(s);
    step_hi(s);
    chk(s == 1'b1, "R5 enable after one cycle", int'(s), 1);
  endtask

  task automatic t_oe_divn();
    logic s;
    int h, l, lows;
    code = 3'd3;
    wait_rise();
    run_len(h, l);
    run_len(h, l);
    // now at first high cycle of a /16 period
    step_hi(s);
    step_hi(s);
    oe = 1'b0;
    h = 3;
    for (int i = 0; i < 20; i++) begin
      step_hi(s);
      if (!s) break;
      h++;
    end
    chk(h == 8, "R6 disable keeps full high phase", h, 8);
    lows = 0;
    for (int i = 0; i < 11; i++) begin
      step_hi(s);
      if (!s) lows++;
    end
    chk(lows == 11, "R4 stays low while disabled", lows, 11);
    oe = 1'b1;
    lows = 0;
    for (int i = 0; i < 12; i++) begin
      step_hi(s);
      if (!s) lows++;
    end
    chk(lows == 12, "R6 no partial pulse on enable", lows, 12);
    step_hi(s);
    chk(s == 1'b1, "R6 first full pulse starts", int'(s), 1);
    run_len(h, l);
    chk(h == 8 && l == 8, "R6 first pulse full length", h * 100 + l, 808);
  endtask

  task automatic t_code_switch();
    logic s;
    int h, l;
    code = 3'd3;
    wait_rise();
    run_len(h, l);
    step_hi(s);
    step_hi(s);
    step_hi(s);
    code = 3'd0;
    h = 4;
    for (int i = 0; i < 20; i++) begin
      step_hi(s);
      if (!s) break;
      h++;
    end
    chk(h == 8, "R7 old high phase completes", h, 8);
    l = 1;
    for (int i = 0; i < 20; i++) begin
      step_hi(s);
      if (s) break;
      l++;
    end
    chk(l == 8, "R7 old low phase completes", l, 8);
    run_len(h, l);
    chk(h == 1 && l == 1, "R7 new ratio after boundary", h * 100 + l, 101);
  endtask

  task automatic t_reset_mid();
    logic s;
    int h, l;
    code = 3'd4;
    for (int i = 0; i < 20; i++) step_hi(s);
    step_hi(s);
    rst_ni = 1'b0;
    #1;
    chk(fout == 6'h00 && fout_n == 6'h3f, "R8 async reset clears outputs", int'(fout), 0);
    step_lo(s);
    step_hi(s);
    chk(fout == 6'h00 && fout_n == 6'h3f, "R8 held in reset", int'(fout), 0);
    code = 3'd1;
    step_lo(s);
    rst_ni = 1'b1;
    step_hi(s);
    chk(s == 1'b0, "R8 starts with low phase", int'(s), 0);
    wait_rise();
    run_len(h, l);
    chk(h == 2 && l == 2, "R8 ratio after release", h * 100 + l, 202);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    for (int c = 0; c < 8; c++) if (c != 4) t_ratio(3'(c));
    t_bypass();
    t_oe_bypass();
    t_oe_divn();
    t_code_switch();
    t_reset_mid();
    chk(pair_err == 0, "R3 pairs identical and complementary", pair_err, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule